// File: doc/BRIEF.md
# CAN Bit Timing and Synchronization Unit

This unit turns the controller's oscillator clock into time quanta and lays each nominal bit out as a one-quantum synchronization slot, a first timing segment (propagation plus phase 1) and a second phase segment. It marks the quantum that starts each bit and the quantum at which the bus level is taken. A protocol engine uses these two strobes and the sampled bit. Frame decoding stays with that engine.

The unit follows the bus by watching recessive-to-dominant transitions, with logic 1 as recessive and logic 0 as dominant. While the engine reports the bus as idle, such a transition is a hard synchronization: the quantum that holds it becomes the synchronization slot of a new bit. On later transitions it measures the phase error and corrects it within a programmed jump width. A late edge lengthens the first segment. An early edge shortens the second segment. The level can come from one sample or from a majority of three consecutive quanta.

Top module: `can_bit_timing`

## Requirements
- R1: A time quantum lasts `brp_sel`+1 clock cycles. With no falling edges, `bit_start_stb` pulses repeat every (`tseg1_sel`+1 + `tseg2_sel`+1 + 1)·(`brp_sel`+1) cycles.
- R2: Each bit is one synchronization quantum, then `tseg1_sel`+1 quanta, then `tseg2_sel`+1 quanta. `sample_stb` marks the last quantum of the first segment, and `rx_bit` takes its new value only with `sample_stb`. The first quantum after reset is a synchronization quantum.
- R3: Each strobe is high for one clock cycle, in the cycle after the quantum it marks. The two strobes are never high together.
- R4: Only a change from 1 (recessive) in the previous quantum to 0 (dominant) in the current quantum counts as an edge. An edge that falls in the synchronization quantum leaves the bit timing unchanged.
- R5: With `hard_sync_en` high, the quantum holding an edge becomes the synchronization quantum of a new bit, wherever the count stood. `tx_dominant` does not block this.
- R6: An edge in the first segment, e quanta after the synchronization quantum, lengthens that segment by min(e, `sjw_sel`+1) quanta.
- R7: An edge in the second segment that lies e quanta before its nominal end (counting the edge quantum) shortens that segment. If e ≤ `sjw_sel`+1, the edge quantum becomes the next synchronization quantum. Otherwise the segment is shortened by `sjw_sel`+1 quanta.
- R8: After the first edge in a bit, any later edge in the same bit gives no resynchronization.
- R9: While `tx_dominant` is high, an edge gives no resynchronization.
- R10: With `triple_en` high, the sampled value is the majority of the levels in the sample quantum and the two quanta before it. With `triple_en` low, it is the level in the sample quantum.
- R11: During reset, `rx_bit` is 1 and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| brp_sel | input | 6 | Prescaler code; quantum = code+1 clocks |
| tseg1_sel | input | 4 | First segment code; length = code+1 quanta |
| tseg2_sel | input | 3 | Second phase segment code; length = code+1 quanta |
| sjw_sel | input | 2 | Jump width code; width = code+1 quanta |
| triple_en | input | 1 | Selects three-sample majority |
| hard_sync_en | input | 1 | Bus idle: the next edge hard-synchronizes |
| tx_dominant | input | 1 | Node is driving a dominant bit; no resynchronization |
| rx_raw | input | 1 | Received bus level (0 dominant) |
| rx_bit | output | 1 | Sampled bit value |
| sample_stb | output | 1 | One-cycle sample point strobe |
| bit_start_stb | output | 1 | One-cycle strobe marking a synchronization quantum |

## Verification
The bench builds the unit with its default field widths. For most of the run it sets the prescaler to one clock per quantum, so every clock edge is a quantum and the edge positions can be placed exactly. It uses a first segment of 4 quanta, a second of 3 and jump widths of 1 and 2. With these values, edges that fall in each quantum of a bit show both cases of the jump-width limit and both outcomes of the early-edge rule. The prescaler is then set to three clocks per quantum to confirm the quantum length and the strobe width.

// File: rtl/can_bt_pkg.sv
`timescale 1ns/1ps
// Shared types for the CAN bit timing unit.
package can_bt_pkg;
    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_PH1  = 2'd1,
        SEG_PH2  = 2'd2
    } seg_e;
endpackage

// File: rtl/can_bt_prescaler.sv
`timescale 1ns/1ps
// Quantum prescaler: raises tq_tick for one clock every brp_sel+1 clocks.
// Assumes brp_sel may change at any time; >= comparison avoids a long wrap.
module can_bt_prescaler #(
    parameter int BRP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BRP_W-1:0] brp_sel,
    output logic             tq_tick
);
    logic [BRP_W-1:0] div_cnt;

    assign tq_tick = (div_cnt >= brp_sel);

    // Count clocks inside the current quantum.
    always_ff @(posedge clk) begin
        if (!rst_n)       div_cnt <= '0;
        else if (tq_tick) div_cnt <= '0;
        else              div_cnt <= div_cnt + 1'b1;
    end
endmodule

// File: rtl/can_bt_vote.sv
`timescale 1ns/1ps
// Keeps the bus level of the two previous quanta. Gives the previous level
// for edge detection and the single- or three-sample bit value.
// Assumes rx_raw is already synchronized to clk.
module can_bt_vote (
    input  logic clk,
    input  logic rst_n,
    input  logic tq_tick,
    input  logic rx_raw,
    input  logic triple_en,
    output logic prev_rx,
    output logic vote_bit
);
    logic [1:0] hist;
    logic       maj;

    // Shift in the level seen in each quantum.
    always_ff @(posedge clk) begin
        if (!rst_n)       hist <= 2'b11;
        else if (tq_tick) hist <= {hist[0], rx_raw};
    end

    // Majority of the two older quanta and the current one.
    always_comb begin
        maj      = (hist[1] & hist[0]) | (hist[1] & rx_raw) | (hist[0] & rx_raw);
        vote_bit = triple_en ? maj : rx_raw;
    end

    assign prev_rx = hist[0];
endmodule

// File: rtl/can_bt_seq.sv
`timescale 1ns/1ps
// Segment sequencer: walks sync / phase-1 / phase-2 quanta and handles
// hard synchronization and jump-width-limited resynchronization.
// Assumes timing fields change only near a bit start.
module can_bt_seq
    import can_bt_pkg::*;
#(
    parameter int TS1_W = 4,
    parameter int TS2_W = 3,
    parameter int SJW_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tq_tick,
    input  logic             rx_raw,
    input  logic             prev_rx,
    input  logic             vote_bit,
    input  logic             hard_sync_en,
    input  logic             tx_dominant,
    input  logic [TS1_W-1:0] tseg1_sel,
    input  logic [TS2_W-1:0] tseg2_sel,
    input  logic [SJW_W-1:0] sjw_sel,
    output logic             rx_bit,
    output logic             sample_stb,
    output logic             bit_start_stb
);
    localparam int WMAX  = (TS1_W > TS2_W) ? ((TS1_W > SJW_W) ? TS1_W : SJW_W)
                                           : ((TS2_W > SJW_W) ? TS2_W : SJW_W);
    localparam int CNT_W = WMAX + 2;

    seg_e             seg_q, seg_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, ext_q, ext_d, shr_q, shr_d;
    logic             used_q, used_d, smp_d, start_d;
    logic             falling, hsync, rsync;
    logic [CNT_W-1:0] jump_w, ts1_base, ts2_len, lag, lead;

    // Edge classification and derived lengths.
    always_comb begin
        falling  = tq_tick & prev_rx & ~rx_raw;
        hsync    = falling & hard_sync_en;
        rsync    = falling & ~hard_sync_en & ~used_q & ~tx_dominant;
        jump_w   = CNT_W'(sjw_sel) + 1'b1;
        ts1_base = CNT_W'(tseg1_sel);
        ts2_len  = CNT_W'(tseg2_sel) + 1'b1;
        lag      = cnt_q + 1'b1;
        lead     = ts2_len - cnt_q;
    end

    // Next-state logic for one quantum.
    always_comb begin
        seg_d   = seg_q;
        cnt_d   = cnt_q;
        ext_d   = ext_q;
        shr_d   = shr_q;
        used_d  = used_q;
        smp_d   = 1'b0;
        start_d = 1'b0;
        if (tq_tick) begin
            if (hsync) begin
                start_d = 1'b1;
                seg_d   = SEG_PH1;
                cnt_d   = '0;
                ext_d   = '0;
                shr_d   = '0;
                used_d  = 1'b1;
            end else begin
                case (seg_q)
                    SEG_SYNC: begin
                        start_d = 1'b1;
                        seg_d   = SEG_PH1;
                        cnt_d   = '0;
                        ext_d   = '0;
                        shr_d   = '0;
                        used_d  = falling;
                    end
                    SEG_PH1: begin
                        if (rsync) begin
                            ext_d  = (lag < jump_w) ? lag : jump_w;
                            used_d = 1'b1;
                        end
                        if (cnt_q >= ts1_base + ext_d) begin
                            smp_d = 1'b1;
                            seg_d = SEG_PH2;
                            cnt_d = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                    SEG_PH2: begin
                        if (rsync && (lead <= jump_w)) begin
                            start_d = 1'b1;
                            seg_d   = SEG_PH1;
                            cnt_d   = '0;
                            ext_d   = '0;
                            shr_d   = '0;
                            used_d  = 1'b1;
                        end else begin
                            if (rsync) begin
                                shr_d  = jump_w;
                                used_d = 1'b1;
                            end
                            if (cnt_q >= ts2_len - 1'b1 - shr_d) begin
                                seg_d = SEG_SYNC;
                                cnt_d = '0;
                            end else begin
                                cnt_d = cnt_q + 1'b1;
                            end
                        end
                    end
                    default: begin
                        seg_d = SEG_SYNC;
                        cnt_d = '0;
                    end
                endcase
            end
        end
    end

    // State, strobes and sampled bit registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q         <= SEG_SYNC;
            cnt_q         <= '0;
            ext_q         <= '0;
            shr_q         <= '0;
            used_q        <= 1'b0;
            rx_bit        <= 1'b1;
            sample_stb    <= 1'b0;
            bit_start_stb <= 1'b0;
        end else begin
            seg_q         <= seg_d;
            cnt_q         <= cnt_d;
            ext_q         <= ext_d;
            shr_q         <= shr_d;
            used_q        <= used_d;
            sample_stb    <= smp_d;
            bit_start_stb <= start_d;
            if (smp_d) rx_bit <= vote_bit;
        end
    end
endmodule

// File: rtl/can_bit_timing.sv
`timescale 1ns/1ps
// CAN bit timing unit top: prescaler, sample history and segment sequencer.
// Assumes rx_raw is synchronized to clk; 0 is the dominant level.
module can_bit_timing #(
    parameter int BRP_W = 6,
    parameter int TS1_W = 4,
    parameter int TS2_W = 3,
    parameter int SJW_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BRP_W-1:0] brp_sel,
    input  logic [TS1_W-1:0] tseg1_sel,
    input  logic [TS2_W-1:0] tseg2_sel,
    input  logic [SJW_W-1:0] sjw_sel,
    input  logic             triple_en,
    input  logic             hard_sync_en,
    input  logic             tx_dominant,
    input  logic             rx_raw,
    output logic             rx_bit,
    output logic             sample_stb,
    output logic             bit_start_stb
);
    logic tq_tick;
    logic prev_rx;
    logic vote_bit;

    can_bt_prescaler #(.BRP_W(BRP_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .brp_sel (brp_sel),
        .tq_tick (tq_tick)
    );

    can_bt_vote u_vote (
        .clk       (clk),
        .rst_n     (rst_n),
        .tq_tick   (tq_tick),
        .rx_raw    (rx_raw),
        .triple_en (triple_en),
        .prev_rx   (prev_rx),
        .vote_bit  (vote_bit)
    );

    can_bt_seq #(.TS1_W(TS1_W), .TS2_W(TS2_W), .SJW_W(SJW_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .tq_tick       (tq_tick),
        .rx_raw        (rx_raw),
        .prev_rx       (prev_rx),
        .vote_bit      (vote_bit),
        .hard_sync_en  (hard_sync_en),
        .tx_dominant   (tx_dominant),
        .tseg1_sel     (tseg1_sel),
        .tseg2_sel     (tseg2_sel),
        .sjw_sel       (sjw_sel),
        .rx_bit        (rx_bit),
        .sample_stb    (sample_stb),
        .bit_start_stb (bit_start_stb)
    );
endmodule

// File: rtl/can_bit_timing_chk.sv
`timescale 1ns/1ps
// Property checker for can_bit_timing, attached by bind below.
// Counts quanta since the last bit start to bound the sample point.
module can_bit_timing_chk #(
    parameter int TS1_W = 4,
    parameter int SJW_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tq_tick,
    input logic             sample_stb,
    input logic             bit_start_stb,
    input logic             rx_bit,
    input logic [TS1_W-1:0] tseg1_sel,
    input logic [SJW_W-1:0] sjw_sel
);
    logic       seen_q;
    logic       smp_seen_q;
    logic [7:0] qcnt_q;

    // Remember a bit start until the next quantum tick.
    always_ff @(posedge clk) begin
        if (!rst_n)       seen_q <= 1'b0;
        else if (tq_tick) seen_q <= 1'b0;
        else              seen_q <= seen_q | bit_start_stb;
    end

    // Quanta elapsed since the synchronization quantum.
    always_ff @(posedge clk) begin
        if (!rst_n) qcnt_q <= '0;
        else if (tq_tick) begin
            if (seen_q || bit_start_stb) qcnt_q <= 8'd1;
            else if (qcnt_q != 8'hFF)    qcnt_q <= qcnt_q + 8'd1;
        end
    end

    // Whether this bit has already produced its sample.
    always_ff @(posedge clk) begin
        if (!rst_n)             smp_seen_q <= 1'b0;
        else if (bit_start_stb) smp_seen_q <= 1'b0;
        else if (sample_stb)    smp_seen_q <= 1'b1;
    end

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_stb && bit_start_stb)); // R3

    AST_STROBES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb || bit_start_stb) |-> $past(tq_tick)); // R1

    AST_RXBIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |-> $stable(rx_bit)); // R2

    AST_ONE_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> !smp_seen_q); // R2

    AST_SAMPLE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> ((qcnt_q >= 8'(tseg1_sel) + 8'd1) &&
                        (qcnt_q <= 8'(tseg1_sel) + 8'(sjw_sel) + 8'd2))); // R6
endmodule

bind can_bit_timing can_bit_timing_chk #(.TS1_W(TS1_W), .SJW_W(SJW_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tq_tick       (tq_tick),
    .sample_stb    (sample_stb),
    .bit_start_stb (bit_start_stb),
    .rx_bit        (rx_bit),
    .tseg1_sel     (tseg1_sel),
    .sjw_sel       (sjw_sel)
);

// File: tb/can_bit_timing_tb.sv
`timescale 1ns/1ps
module can_bit_timing_tb;
    localparam real CLK_NS = 8.0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] brp_sel = 6'd0;
    logic [3:0] tseg1_sel = 4'd3;   // first segment 4 quanta
    logic [2:0] tseg2_sel = 3'd2;   // second segment 3 quanta
    logic [1:0] sjw_sel = 2'd0;
    logic       triple_en = 1'b0;
    logic       hard_sync_en = 1'b0;
    logic       tx_dominant = 1'b0;
    logic       rx_raw = 1'b1;
    logic       rx_bit, sample_stb, bit_start_stb;

    int n_cmp = 0;
    int n_bad = 0;
    int n_both = 0;

    always #(CLK_NS/2.0) clk = ~clk;

    can_bit_timing u_dut (
        .clk(clk), .rst_n(rst_n), .brp_sel(brp_sel), .tseg1_sel(tseg1_sel),
        .tseg2_sel(tseg2_sel), .sjw_sel(sjw_sel), .triple_en(triple_en),
        .hard_sync_en(hard_sync_en), .tx_dominant(tx_dominant), .rx_raw(rx_raw),
        .rx_bit(rx_bit), .sample_stb(sample_stb), .bit_start_stb(bit_start_stb)
    );

    // Edge-offset table: k = quanta after an observed bit start at which the
    // falling edge occurs; db/ds = quanta from edge to next bit start / sample.
    typedef struct packed {
        logic [3:0] req;
        logic       hs;
        logic       txd;
        logic [1:0] sjw;
        logic [3:0] k;
        logic [4:0] db;
        logic [4:0] ds;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{4'd6,  1'b0, 1'b0, 2'd0, 4'd1, 5'd8, 5'd4},  // R6 late by 1
        '{4'd6,  1'b0, 1'b0, 2'd0, 4'd2, 5'd7, 5'd3},  // R6 capped at 1
        '{4'd6,  1'b0, 1'b0, 2'd0, 4'd4, 5'd5, 5'd1},  // R6 edge at sample quantum
        '{4'd6,  1'b0, 1'b0, 2'd1, 4'd2, 5'd8, 5'd4},  // R6 full 2 within width 2
        '{4'd7,  1'b0, 1'b0, 2'd0, 4'd5, 5'd2, 5'd6},  // R7 shorten by 1
        '{4'd7,  1'b0, 1'b0, 2'd0, 4'd6, 5'd1, 5'd5},  // R7 shorten ends now
        '{4'd7,  1'b0, 1'b0, 2'd0, 4'd7, 5'd0, 5'd4},  // R7 edge quantum is sync
        '{4'd7,  1'b0, 1'b0, 2'd1, 4'd6, 5'd0, 5'd4},  // R7 within width 2
        '{4'd4,  1'b0, 1'b0, 2'd0, 4'd8, 5'd0, 5'd4},  // R4 edge in sync quantum
        '{4'd5,  1'b1, 1'b0, 2'd0, 4'd2, 5'd0, 5'd4},  // R5 hard sync in segment 1
        '{4'd5,  1'b1, 1'b0, 2'd0, 4'd6, 5'd0, 5'd4},  // R5 hard sync in segment 2
        '{4'd9,  1'b0, 1'b1, 2'd0, 4'd2, 5'd6, 5'd2},  // R9 no resync while sending
        '{4'd5,  1'b1, 1'b1, 2'd0, 4'd3, 5'd0, 5'd4}   // R5 hard sync despite tx
    };

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One quantum (brp_sel = 0): drive level, let the edge pass, then observe.
    task automatic q_step(input logic v);
        rx_raw = v;
        @(posedge clk);
        #2;
        if (sample_stb && bit_start_stb) n_both++;
    endtask

    task automatic align();
        for (int i = 0; i < 40; i++) begin
            q_step(1'b1);
            if (bit_start_stb) break;
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(CLK_NS * 200000.0);
        n_bad++;
        $display("FAIL watchdog R1: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int db, ds, gap, width_bad;
        // R11: reset values
        repeat (3) @(posedge clk);
        #2;
        check("R11 rx_bit", rx_bit, 1);
        check("R11 sample_stb", sample_stb, 0);
        check("R11 bit_start_stb", bit_start_stb, 0);
        rst_n = 1'b1;
        q_step(1'b1);
        check("R2 first quantum is sync", bit_start_stb, 1);

        // Edge-position table
        for (int i = 0; i < NV; i++) begin
            align();
            sjw_sel = VECS[i].sjw;
            for (int j = 1; j < int'(VECS[i].k); j++) q_step(1'b1);
            hard_sync_en = VECS[i].hs;
            tx_dominant  = VECS[i].txd;
            q_step(1'b0);
            hard_sync_en = 1'b0;
            tx_dominant  = 1'b0;
            db = bit_start_stb ? 0 : -1;
            ds = sample_stb ? 0 : -1;
            for (int d = 1; d < 30 && (db < 0 || ds < 0); d++) begin
                q_step(1'b0);
                if (bit_start_stb && db < 0) db = d;
                if (sample_stb && ds < 0) ds = d;
            end
            check($sformatf("R%0d row %0d bit start", VECS[i].req, i), db, int'(VECS[i].db));
            check($sformatf("R%0d row %0d sample", VECS[i].req, i), ds, int'(VECS[i].ds));
        end
        sjw_sel = 2'd0;

        // R8: second edge in the same bit is ignored (width 2)
        align();
        sjw_sel = 2'd1;
        q_step(1'b0);           // edge, late by 1
        q_step(1'b1);
        q_step(1'b0);           // second edge, late by 3
        ds = sample_stb ? 2 : -1;
        q_step(1'b0);
        if (ds < 0 && sample_stb) ds = 3;
        q_step(1'b0);
        if (ds < 0 && sample_stb) ds = 4;
        q_step(1'b0);
        if (ds < 0 && sample_stb) ds = 5;
        check("R8 one resync per bit", ds, 4);
        sjw_sel = 2'd0;

        // R10: single and three-sample values, edges blocked via tx_dominant
        tx_dominant = 1'b1;
        triple_en = 1'b0;
        align();
        q_step(1'b1); q_step(1'b0); q_step(1'b0); q_step(1'b1);
        check("R10 single sample strobe", sample_stb, 1);
        check("R10 single sample value", rx_bit, 1);
        triple_en = 1'b1;
        align();
        q_step(1'b1); q_step(1'b0); q_step(1'b0); q_step(1'b1);
        check("R10 majority 0,0,1", rx_bit, 0);
        align();
        q_step(1'b0); q_step(1'b1); q_step(1'b1); q_step(1'b0);
        check("R10 majority 1,1,0", rx_bit, 1);
        triple_en = 1'b0;
        align();
        q_step(1'b0); q_step(1'b1); q_step(1'b1); q_step(1'b0);
        check("R10 single sample of 0", rx_bit, 0);

        // R1/R2: bit period with one clock per quantum
        align();
        gap = 0;
        for (int c = 1; c < 40; c++) begin
            q_step(1'b1);
            if (bit_start_stb) begin gap = c; break; end
        end
        check("R2 bit length in quanta", gap, 8);

        // R1/R3: three clocks per quantum
        brp_sel = 6'd2;
        align();
        align();
        gap = 0;
        width_bad = 0;
        for (int c = 1; c < 100; c++) begin
            q_step(1'b1);
            if (c == 1 && bit_start_stb) width_bad = 1;
            if (bit_start_stb) begin gap = c; break; end
        end
        check("R1 bit period in clocks", gap, 24);
        check("R3 strobe one clock wide", width_bad, 0);
        check("R3 strobes never together", n_both, 0);
        tx_dominant = 1'b0;
        brp_sel = 6'd0;

        summary();
        $finish;
    end
endmodule